// File: doc/BRIEF.md
# Mask-Selected Serial Bit Shifter

This block sends bytes one bit at a time over a small group of general-purpose output pins. A single configuration word picks which of the low eight port pins act as the serial clock, which act as serial data, and whether a byte leaves most-significant bit first. Once a valid configuration is in place, each byte taken through a valid/ready handshake is sent as eight clock pulses. Each pulse has three phases. The clock pins drop first. The data pins then take the bit value. Finally the clock pins rise. This suits loading a bitstream into a programmable device through spare port pins.

The block sits between the port's ordinary output register and the pads. It receives the port's normal output value and passes it through unchanged, except on the pins that the current configuration selects. On those pins it drives its own held levels. When a configuration is accepted, the held levels are seeded from the port's current value, so the selected pins do not jump at configuration time. Every phase lasts a programmable number of system clock cycles, so the data pins are settled for at least one full phase before the clock rises.

Top module: `pin_shift_tx`

## Requirements
- R1: The configuration word carries the clock-pin mask in bits 7:0, the data-pin mask in bits 15:8 and the MSB-first flag in bit 16. Mask bit i selects port pin i.
- R2: A configuration write is accepted only when each of the two masks shares at least one pin with the writable pins and at least one pin with `pin_oe`. Otherwise both masks become zero and `cfg_err` is high for the one cycle after the write.
- R3: While either mask is zero, `byte_ready` is low. A byte offered then is not sent, `perm_err` is high for the one cycle after the offer, and `port_out` is unaffected.
- R4: With N = `phase_len` (0 treated as 1), each bit occupies 3N cycles in order. First come N cycles with the clock pins low and the data pins at their previous level. Next come N cycles with the clock pins still low and the data pins at the new bit. Last come N cycles with the clock pins high.
- R5: With the MSB-first flag set, bits leave in the order 7 down to 0. Otherwise they leave in the order 0 up to 7. All data-mask pins carry the same bit.
- R6: A byte is exactly eight rising edges on the clock pins. `byte_ready` is low for exactly 24N cycles, starting in the cycle after acceptance.
- R7: Port bits outside both masks, and all bits above bit 7, follow `port_base` in every cycle.
- R8: A configuration write while a byte is in progress is ignored. A write on the same edge that accepts a byte is also ignored, and neither case raises `cfg_err`.
- R9: After reset both masks are zero, the MSB-first flag is 0, `byte_ready` is low and `port_out` equals `port_base`.
- R10: On an accepted configuration, the selected pins keep the level `port_base` had on that edge, until shifting drives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_word | input | 17 | Clock mask, data mask and bit-order flag |
| pin_oe | input | 8 | Output-enable state of port pins 7:0 |
| phase_len | input | PHASE_W | Cycles per phase, sampled when a byte is accepted |
| byte_valid | input | 1 | Byte offered |
| byte_data | input | 8 | Byte to send |
| byte_ready | output | 1 | Byte can be accepted |
| port_base | input | PORT_W | Port's ordinary output value |
| port_out | output | PORT_W | Port value with the selected pins driven by the shifter |
| cfg_err | output | 1 | One-cycle pulse: configuration refused |
| perm_err | output | 1 | One-cycle pulse: byte offered with no valid configuration |

## Verification
Two functions can meet on the same edge. One is a configuration write, and the other is either acceptance of a byte or the final edge of a byte still in flight. The bench raises `cfg_wr` and `byte_valid` together while idle, and it also writes a configuration partway through a byte. A clock-and-data monitor then confirms that the whole byte left on the previously configured pins and that no `cfg_err` appeared. A behavioural model, driven by cycle position within the byte, is compared with every output on every clock. The same comparison runs while the unrelated port bits change at random.

// File: rtl/pst_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the mask-selected serial shifter.
// Assumes the configuration word layout is fixed at 17 bits.
package pst_pkg;
    localparam int MASK_W = 8;
    localparam int BYTE_W = 8;
    localparam int CFG_W  = 2 * MASK_W + 1;
    localparam int BITS_PER_BYTE = BYTE_W;

    // Phase of the current bit; IDLE when no byte is in flight.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_DATA = 2'd2,
        PH_HIGH = 2'd3
    } phase_t;

    // Packed so that bit 16 is the order flag, 15:8 data mask, 7:0 clock mask.
    typedef struct packed {
        logic              msb_first;
        logic [MASK_W-1:0] dat;
        logic [MASK_W-1:0] clk;
    } cfg_t;
endpackage

// File: rtl/pst_cfg.sv
`timescale 1ns/1ps
// Configuration holder: validates a configuration write against the
// writable and output-enabled pins and keeps the accepted masks.
// Assumes the caller has already blocked writes during shifting.
module pst_cfg
    import pst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  cfg_t              word,
    input  logic [MASK_W-1:0] writable,
    input  logic [MASK_W-1:0] oe,
    output logic [MASK_W-1:0] clk_mask,
    output logic [MASK_W-1:0] dat_mask,
    output logic              msb_first,
    output logic              take,
    output logic              cfg_err
);
    logic fits;

    // Both masks must reach a writable pin and an enabled output.
    assign fits = (|(word.clk & writable)) && (|(word.dat & writable)) &&
                  (|(word.clk & oe))       && (|(word.dat & oe));
    assign take = wr_en && fits;

    // Store accepted masks, clear them on refusal, pulse the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_mask  <= '0;
            dat_mask  <= '0;
            msb_first <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            cfg_err <= 1'b0;
            if (wr_en) begin
                if (fits) begin
                    clk_mask  <= word.clk;
                    dat_mask  <= word.dat;
                    msb_first <= word.msb_first;
                end else begin
                    clk_mask <= '0;
                    dat_mask <= '0;
                    cfg_err  <= 1'b1;
                end
            end
        end
    end

    // R2: a refusal always leaves both masks empty
    a_r2_reject_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (clk_mask == '0 && dat_mask == '0));
endmodule

// File: rtl/pst_seq.sv
`timescale 1ns/1ps
// Bit sequencer: walks one byte through eight bits of three phases each.
// It emits one-cycle events that tell the pin holder what to change on
// the next edge. Assumes start is only raised while idle.
module pst_seq
    import pst_pkg::*;
#(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BYTE_W-1:0]  byte_in,
    input  logic               msb_first,
    input  logic [PHASE_W-1:0] phase_len,
    output logic               busy,
    output logic               ev_lo,
    output logic               ev_data,
    output logic               ev_bit,
    output logic               ev_hi
);
    localparam int IDX_W = $clog2(BITS_PER_BYTE);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BITS_PER_BYTE - 1);

    phase_t             ph;
    logic [PHASE_W-1:0] cnt;
    logic [PHASE_W-1:0] n_lat;
    logic [IDX_W-1:0]   bitn;
    logic [BYTE_W-1:0]  sh;
    logic               msb_lat;
    logic               last;
    logic [3:0]         hi_seen;

    assign busy    = (ph != PH_IDLE);
    assign last    = (cnt == n_lat - 1'b1);
    assign ev_lo   = start || (ph == PH_HIGH && last && bitn != LAST_IDX);
    assign ev_data = (ph == PH_LOW) && last;
    assign ev_hi   = (ph == PH_DATA) && last;
    assign ev_bit  = msb_lat ? sh[BYTE_W-1] : sh[0];

    // Phase, cycle counter, bit index and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            n_lat   <= PHASE_W'(1);
            bitn    <= '0;
            sh      <= '0;
            msb_lat <= 1'b0;
        end else if (start) begin
            ph      <= PH_LOW;
            cnt     <= '0;
            n_lat   <= (phase_len == '0) ? PHASE_W'(1) : phase_len;
            bitn    <= '0;
            sh      <= byte_in;
            msb_lat <= msb_first;
        end else if (busy) begin
            if (!last) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                case (ph)
                    PH_LOW:  ph <= PH_DATA;
                    PH_DATA: ph <= PH_HIGH;
                    PH_HIGH: begin
                        if (bitn == LAST_IDX) begin
                            ph <= PH_IDLE;
                        end else begin
                            ph   <= PH_LOW;
                            bitn <= bitn + 1'b1;
                            sh   <= msb_lat ? (sh << 1) : (sh >> 1);
                        end
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end

    // Counts clock rises within the current byte, for the pulse check.
    always_ff @(posedge clk) begin
        if (!rst_n || start) hi_seen <= '0;
        else if (ev_hi)      hi_seen <= hi_seen + 1'b1;
    end

    // R6: the last high phase ends after exactly eight clock rises
    a_r6_eight_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_HIGH && last && bitn == LAST_IDX) |-> (hi_seen == 4'd8));

    // R4: the high phase is only reached from the data phase
    a_r4_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_HIGH) |-> ($past(ph) == PH_DATA || $past(ph) == PH_HIGH));
endmodule

// File: rtl/pst_pinmux.sv
`timescale 1ns/1ps
// Pin holder: keeps the levels driven on the selected pins and merges
// them with the port's ordinary value. Assumes events and load never
// occur together (load only happens while idle).
module pst_pinmux
    import pst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MASK_W-1:0] base_lo,
    input  logic [MASK_W-1:0] clk_mask,
    input  logic [MASK_W-1:0] dat_mask,
    input  logic              ev_lo,
    input  logic              ev_data,
    input  logic              ev_bit,
    input  logic              ev_hi,
    output logic [MASK_W-1:0] pins_lo
);
    logic [MASK_W-1:0] held;
    logic [MASK_W-1:0] held_nx;
    logic [MASK_W-1:0] drv;

    // Apply clock-low, data and clock-high updates in that order.
    always_comb begin
        held_nx = held;
        if (ev_lo)   held_nx = held_nx & ~clk_mask;
        if (ev_data) held_nx = ev_bit ? (held_nx | dat_mask) : (held_nx & ~dat_mask);
        if (ev_hi)   held_nx = held_nx | clk_mask;
    end

    // Held levels: seeded from the port on configuration, then shifted.
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (load) held <= base_lo;
        else           held <= held_nx;
    end

    assign drv     = clk_mask | dat_mask;
    assign pins_lo = (held & drv) | (base_lo & ~drv);
endmodule

// File: rtl/pin_shift_tx.sv
`timescale 1ns/1ps
// Mask-selected serial bit shifter, top level. Takes a configuration word
// and bytes over valid/ready, and drives the selected low port pins as a
// serial clock and data. Assumes PORT_W >= 8 and that WRITABLE is fixed.
module pin_shift_tx
    import pst_pkg::*;
#(
    parameter int               PORT_W   = 18,
    parameter int               PHASE_W  = 8,
    parameter logic [PORT_W-1:0] WRITABLE = {PORT_W{1'b1}}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CFG_W-1:0]   cfg_word,
    input  logic [MASK_W-1:0]  pin_oe,
    input  logic [PHASE_W-1:0] phase_len,
    input  logic               byte_valid,
    input  logic [BYTE_W-1:0]  byte_data,
    output logic               byte_ready,
    input  logic [PORT_W-1:0]  port_base,
    output logic [PORT_W-1:0]  port_out,
    output logic               cfg_err,
    output logic               perm_err
);
    localparam int HIGH_W = PORT_W - MASK_W;

    cfg_t              word_in;
    logic [MASK_W-1:0] clk_mask;
    logic [MASK_W-1:0] dat_mask;
    logic [MASK_W-1:0] pins_lo;
    logic              msb_first;
    logic              cfg_take;
    logic              cfg_en;
    logic              busy;
    logic              masks_ok;
    logic              accept;
    logic              ev_lo, ev_data, ev_bit, ev_hi;

    assign word_in    = cfg_t'(cfg_word);
    assign masks_ok   = (|clk_mask) && (|dat_mask);
    assign byte_ready = !busy && masks_ok;
    assign accept     = byte_valid && byte_ready;
    assign cfg_en     = cfg_wr && !busy && !accept;

    // Flag a byte offered while no usable configuration exists.
    always_ff @(posedge clk) begin
        if (!rst_n) perm_err <= 1'b0;
        else        perm_err <= byte_valid && !busy && !masks_ok;
    end

    pst_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_en),
        .word      (word_in),
        .writable  (WRITABLE[MASK_W-1:0]),
        .oe        (pin_oe),
        .clk_mask  (clk_mask),
        .dat_mask  (dat_mask),
        .msb_first (msb_first),
        .take      (cfg_take),
        .cfg_err   (cfg_err)
    );

    pst_seq #(.PHASE_W(PHASE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .byte_in   (byte_data),
        .msb_first (msb_first),
        .phase_len (phase_len),
        .busy      (busy),
        .ev_lo     (ev_lo),
        .ev_data   (ev_data),
        .ev_bit    (ev_bit),
        .ev_hi     (ev_hi)
    );

    pst_pinmux u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_take),
        .base_lo  (port_base[MASK_W-1:0]),
        .clk_mask (clk_mask),
        .dat_mask (dat_mask),
        .ev_lo    (ev_lo),
        .ev_data  (ev_data),
        .ev_bit   (ev_bit),
        .ev_hi    (ev_hi),
        .pins_lo  (pins_lo)
    );

    // Upper port bits pass straight through when the port is wider than a mask.
    generate
        if (HIGH_W > 0) begin : g_wide
            assign port_out = {port_base[PORT_W-1:MASK_W], pins_lo};
        end else begin : g_narrow
            assign port_out = pins_lo;
        end
    endgenerate

    // R4: data pins hold steady across the clock rise
    a_r4_data_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(ev_hi)) |-> $stable(pins_lo & dat_mask & ~clk_mask));

    // R3: a permission error follows a refused offer
    a_r3_perm_cause: assert property (@(posedge clk) disable iff (!rst_n)
        perm_err |-> $past(byte_valid && !byte_ready && !busy));

    // R8: masks cannot change while a byte is in flight
    a_r8_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr) |=> ($stable(clk_mask) && $stable(dat_mask)));

    // R3: no readiness without both masks
    a_r3_ready_needs_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_mask == '0 || dat_mask == '0) |-> !byte_ready);
endmodule

// File: tb/test_pin_shift_tx.sv
`timescale 1ns/1ps
// Bench for pin_shift_tx: behavioural reference model compared every clock,
// plus a clock/data pin monitor that rebuilds each sent byte.
module test_pin_shift_tx;
    localparam int PORT_W  = 18;
    localparam int PHASE_W = 8;
    localparam logic [PORT_W-1:0] BENCH_WR = 18'h3FF0F; // pins 7:4 not writable

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_wr = 1'b0;
    logic [16:0]        cfg_word = '0;
    logic [7:0]         pin_oe = '0;
    logic [PHASE_W-1:0] phase_len = 8'd1;
    logic               byte_valid = 1'b0;
    logic [7:0]         byte_data = '0;
    logic               byte_ready;
    logic [PORT_W-1:0]  port_base = 18'h155AA;
    logic [PORT_W-1:0]  port_out;
    logic               cfg_err, perm_err;

    int total = 0;
    int bad = 0;
    string cur_req = "R9";
    bit jitter = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pin_shift_tx #(.PORT_W(PORT_W), .PHASE_W(PHASE_W), .WRITABLE(BENCH_WR)) i_pin_shift_tx (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .pin_oe(pin_oe), .phase_len(phase_len), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_ready(byte_ready), .port_base(port_base),
        .port_out(port_out), .cfg_err(cfg_err), .perm_err(perm_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] m_clk, m_dat, m_held, m_byte;
    logic       m_msb, m_busy, m_cfgerr, m_permerr;
    int         m_t, m_n;

    task automatic apply_phase(input int t);
        int b, p, idx;
        b = t / (3 * m_n);
        p = (t % (3 * m_n)) / m_n;
        idx = m_msb ? 7 - b : b;
        if (p == 0)      m_held = m_held & ~m_clk;
        else if (p == 1) m_held = m_byte[idx] ? (m_held | m_dat) : (m_held & ~m_dat);
        else             m_held = m_held | m_clk;
    endtask

    // pin monitor state
    bit   mon_on = 1'b0;
    int   mon_c = 0, mon_d = 1;
    logic mon_prev = 1'b0;
    logic mon_q[$];

    always @(posedge clk) begin
        logic [7:0] drv;
        logic [PORT_W-1:0] exp_out;
        bit ok_m, have_m, perm_n, cerr_n;
        if (!rst_n) begin
            m_clk = '0; m_dat = '0; m_held = '0; m_byte = '0; m_msb = 1'b0;
            m_busy = 1'b0; m_cfgerr = 1'b0; m_permerr = 1'b0; m_t = 0; m_n = 1;
        end else begin
            have_m = (m_clk != 0) && (m_dat != 0);
            perm_n = byte_valid && !m_busy && !have_m;
            cerr_n = 1'b0;
            if (m_busy) begin
                m_t++;
                if (m_t == 24 * m_n) m_busy = 1'b0;
                else apply_phase(m_t);
            end else if (byte_valid && have_m) begin
                m_busy = 1'b1; m_t = 0; m_byte = byte_data;
                m_n = (phase_len == 0) ? 1 : int'(phase_len);
                apply_phase(0);
            end else if (cfg_wr) begin
                ok_m = ((cfg_word[7:0] & BENCH_WR[7:0]) != 0) && ((cfg_word[15:8] & BENCH_WR[7:0]) != 0)
                    && ((cfg_word[7:0] & pin_oe) != 0) && ((cfg_word[15:8] & pin_oe) != 0);
                if (ok_m) begin
                    m_clk = cfg_word[7:0]; m_dat = cfg_word[15:8]; m_msb = cfg_word[16];
                    m_held = port_base[7:0];
                end else begin
                    m_clk = '0; m_dat = '0; cerr_n = 1'b1;
                end
            end
            m_cfgerr = cerr_n;
            m_permerr = perm_n;
        end
        #1;
        drv = m_clk | m_dat;
        exp_out = {port_base[PORT_W-1:8], (m_held & drv) | (port_base[7:0] & ~drv)};
        check(port_out === exp_out, cur_req, "port_out", 32'(port_out), 32'(exp_out));
        check(byte_ready === (!m_busy && m_clk != 0 && m_dat != 0), cur_req, "byte_ready",
              32'(byte_ready), 32'(!m_busy && m_clk != 0 && m_dat != 0));
        check(cfg_err === m_cfgerr, cur_req, "cfg_err", 32'(cfg_err), 32'(m_cfgerr));
        check(perm_err === m_permerr, cur_req, "perm_err", 32'(perm_err), 32'(m_permerr));
        if (mon_on && port_out[mon_c] && !mon_prev) mon_q.push_back(port_out[mon_d]);
        mon_prev = port_out[mon_c];
    end

    always @(negedge clk) if (jitter) port_base = 18'($urandom);

    // ---------------- stimulus helpers ----------------
    task automatic do_cfg(input logic msb, input logic [7:0] dm, input logic [7:0] cm);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_word = {msb, dm, cm};
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [PHASE_W-1:0] n, output int lowcnt);
        @(negedge clk);
        byte_valid = 1'b1; byte_data = b; phase_len = n;
        while (!byte_ready) @(negedge clk);
        @(negedge clk);
        byte_valid = 1'b0;
        lowcnt = 0;
        while (!byte_ready) begin lowcnt++; @(negedge clk); end
    endtask

    task automatic mon_start(input int c, input int d);
        mon_c = c; mon_d = d; mon_prev = port_out[c]; mon_q.delete(); mon_on = 1'b1;
    endtask

    function automatic logic [7:0] mon_byte(input bit msb);
        logic [7:0] v = '0;
        for (int i = 0; i < 8 && i < mon_q.size(); i++)
            if (msb) v[7 - i] = mon_q[i]; else v[i] = mon_q[i];
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lc;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R9: reset state
        @(negedge clk);
        check(port_out == port_base, "R9", "port_out after reset", 32'(port_out), 32'(port_base));
        check(byte_ready == 1'b0, "R9", "ready after reset", 32'(byte_ready), 0);

        // R3: byte refused with empty masks
        cur_req = "R3";
        byte_valid = 1'b1; byte_data = 8'hFF;
        @(negedge clk); byte_valid = 1'b0;
        check(perm_err == 1'b1, "R3", "perm_err", 32'(perm_err), 1);
        check(port_out == port_base, "R3", "port untouched", 32'(port_out), 32'(port_base));

        // R2: clock mask misses enabled outputs
        cur_req = "R2";
        pin_oe = 8'h0F;
        @(negedge clk); cfg_wr = 1'b1; cfg_word = {1'b1, 8'h01, 8'h10};
        @(negedge clk); cfg_wr = 1'b0;
        check(cfg_err == 1'b1, "R2", "cfg_err oe", 32'(cfg_err), 1);
        check(byte_ready == 1'b0, "R2", "ready after reject", 32'(byte_ready), 0);
        // R2: clock mask only on non-writable pins
        pin_oe = 8'hFF;
        @(negedge clk); cfg_wr = 1'b1; cfg_word = {1'b0, 8'h01, 8'h20};
        @(negedge clk); cfg_wr = 1'b0;
        check(cfg_err == 1'b1, "R2", "cfg_err writable", 32'(cfg_err), 1);

        // R1 / R10: accept clock pin 0, data pin 1, MSB first
        cur_req = "R1";
        port_base = 18'h2A5A6;
        do_cfg(1'b1, 8'h02, 8'h01);
        check(cfg_err == 1'b0, "R1", "no cfg_err", 32'(cfg_err), 0);
        check(port_out == port_base, "R10", "no jump at config", 32'(port_out), 32'(port_base));
        check(byte_ready == 1'b1, "R1", "ready after accept", 32'(byte_ready), 1);

        // R4 / R5 / R6: MSB-first byte, N=1
        cur_req = "R5";
        mon_start(0, 1);
        send_byte(8'hA5, 8'd1, lc);
        mon_on = 1'b0;
        check(lc == 24, "R6", "busy cycles N=1", 32'(lc), 24);
        check(mon_q.size() == 8, "R6", "clock rises", 32'(mon_q.size()), 8);
        check(mon_byte(1'b1) == 8'hA5, "R5", "msb-first byte", 32'(mon_byte(1'b1)), 32'h A5);

        // R5 / R4: LSB-first, two data pins, N=3, random unrelated bits (R7)
        cur_req = "R7";
        do_cfg(1'b0, 8'h06, 8'h08);
        jitter = 1'b1;
        mon_start(3, 2);
        send_byte(8'h3C, 8'd3, lc);
        mon_on = 1'b0;
        jitter = 1'b0;
        check(lc == 72, "R4", "busy cycles N=3", 32'(lc), 72);
        check(mon_byte(1'b0) == 8'h3C, "R5", "lsb-first byte", 32'(mon_byte(1'b0)), 32'h3C);
        check(port_out[17:8] == port_base[17:8], "R7", "upper bits", 32'(port_out[17:8]), 32'(port_base[17:8]));

        // R8: configuration write mid-byte is ignored
        cur_req = "R8";
        port_base = 18'h00000;
        do_cfg(1'b1, 8'h02, 8'h01);
        mon_start(0, 1);
        fork
            send_byte(8'h96, 8'd2, lc);
            begin
                repeat (10) @(negedge clk);
                cfg_wr = 1'b1; cfg_word = {1'b0, 8'h08, 8'h04};
                @(negedge clk); cfg_wr = 1'b0;
                check(cfg_err == 1'b0, "R8", "no cfg_err while busy", 32'(cfg_err), 0);
            end
        join
        mon_on = 1'b0;
        check(mon_byte(1'b1) == 8'h96, "R8", "byte on old pins", 32'(mon_byte(1'b1)), 32'h96);

        // R8: config write and byte offer on the same edge
        mon_start(0, 1);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_word = {1'b0, 8'h08, 8'h04};
        byte_valid = 1'b1; byte_data = 8'h5B; phase_len = 8'd0;   // R4: 0 acts as 1
        @(negedge clk);
        cfg_wr = 1'b0; byte_valid = 1'b0;
        check(cfg_err == 1'b0, "R8", "same-edge cfg_err", 32'(cfg_err), 0);
        lc = 0;
        while (!byte_ready) begin lc++; @(negedge clk); end
        mon_on = 1'b0;
        check(lc == 24, "R4", "phase_len 0 busy cycles", 32'(lc), 24);
        check(mon_byte(1'b1) == 8'h5B, "R8", "same-edge byte order kept", 32'(mon_byte(1'b1)), 32'h5B);

        // R3: after a rejected reconfiguration, bytes are refused again
        cur_req = "R3";
        do_cfg(1'b0, 8'h00, 8'h01);
        @(negedge clk); byte_valid = 1'b1;
        @(negedge clk); byte_valid = 1'b0;
        check(perm_err == 1'b1, "R3", "perm_err after clear", 32'(perm_err), 1);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule